// File: doc/BRIEF.md
# Targeted Line Fetch and Serve Handler

This block sits on the system-bus side of one core's cache controller. It runs a two-phase fetch. A local miss is accepted first. The block then waits for a directory confirmation on the coherence bus. A hit confirmation names the core that owns the line, and the block sends a data request on the system bus aimed only at that core. A miss confirmation sends the request to the L2 cache instead. The line that comes back from the remote core or from L2 is handed to the core as a one-cycle fill.

The same block also answers requests from other cores. When a system-bus request names this core as its destination, the block reads the line from the local cache data array. It returns the message with its stage flipped to response and the line placed in the data field. Every core filters bus traffic using only the stage, source and destination fields, so no full snoop lookup is needed. Only one fetch may be in flight per core.

Top module: `p2p_fetch_top`

## Requirements
- R1: After reset the block accepts a local miss (miss_ready_o high), and sb_tx_valid_o, l2_req_valid_o, rd_en_o and fill_valid_o are all low.
- R2: A local miss is taken when miss_valid_i and miss_ready_o are both high. From that edge until the cycle of its fill, miss_ready_o stays low, and any miss presented in that window is ignored.
- R3: On the coherence bus a message is a confirmation for this core only when cc_stage_i=1 and cc_src_i=core_id_i. Messages with stage 0, with a foreign source, or arriving when no fetch waits for a confirmation have no effect.
- R4: A confirmation with cc_ack_i=0 (hit) makes the block offer one system-bus request. It carries stage 0, the miss category, source=core_id_i, destination=cc_owner_i, the miss address and an all-zero data field.
- R5: A confirmation with cc_ack_i=1 (miss) makes the block raise l2_req_valid_o with the miss address and category until l2_req_ready_i. The next l2_rsp_valid_i produces the fill. A system-bus request is never offered in that case.
- R6: A system-bus message with stage 0 and destination=core_id_i, accepted while sb_rx_ready_o is high, causes rd_en_o with rd_addr_o=its address in the next cycle. rd_data_i is sampled at the end of that cycle. A response is then offered with stage 1, the category, source, destination and address unchanged, and the data set to the read line. sb_rx_ready_o is low from acceptance until that response is sent.
- R7: A stage 0 system-bus message whose destination is not core_id_i causes no read and no transmission.
- R8: A stage 1 system-bus message with source=core_id_i, accepted while a fetch waits for a remote response, completes the fetch with its data. A stage 1 message with a foreign source, or one arriving with no such fetch waiting, has no effect.
- R9: Once sb_tx_valid_o is high it stays high with an unchanged payload until sb_tx_ready_i. A request and a served response that compete both get sent, each intact, one after the other.
- R10: A completed fetch gives fill_valid_o high for exactly one cycle, one cycle after the completing response or L2 reply is taken. It carries the miss address, the category and the line. miss_ready_o is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_id_i | input | ID_W | This core's number |
| miss_valid_i | input | 1 | Local miss presented |
| miss_ready_o | output | 1 | No fetch in flight |
| miss_addr_i | input | ADDR_W | Missing line address |
| miss_cat_i | input | 1 | 0 read, 1 write |
| cc_valid_i | input | 1 | Coherence-bus message valid |
| cc_ready_o | output | 1 | Always high |
| cc_stage_i | input | 1 | 0 directory query, 1 confirmation |
| cc_src_i | input | ID_W | Core that raised the query |
| cc_ack_i | input | 1 | 0 directory hit, 1 directory miss |
| cc_owner_i | input | ID_W | Core holding the line on a hit |
| sb_tx_valid_o | output | 1 | System-bus send valid |
| sb_tx_ready_i | input | 1 | System-bus send ready |
| sb_tx_stage_o | output | 1 | 0 request, 1 response |
| sb_tx_cat_o | output | 1 | Category |
| sb_tx_src_o | output | ID_W | Requesting core |
| sb_tx_dst_o | output | ID_W | Serving core |
| sb_tx_addr_o | output | ADDR_W | Line address |
| sb_tx_data_o | output | LINE_W | Line data |
| sb_rx_valid_i | input | 1 | System-bus receive valid |
| sb_rx_ready_o | output | 1 | Receive ready (low while serving) |
| sb_rx_stage_i | input | 1 | 0 request, 1 response |
| sb_rx_cat_i | input | 1 | Category |
| sb_rx_src_i | input | ID_W | Requesting core |
| sb_rx_dst_i | input | ID_W | Serving core |
| sb_rx_addr_i | input | ADDR_W | Line address |
| sb_rx_data_i | input | LINE_W | Line data |
| rd_en_o | output | 1 | Local line read strobe |
| rd_addr_o | output | ADDR_W | Local line read address |
| rd_data_i | input | LINE_W | Line read, valid the cycle of rd_en_o |
| l2_req_valid_o | output | 1 | L2 request valid |
| l2_req_ready_i | input | 1 | L2 request ready |
| l2_req_addr_o | output | ADDR_W | L2 request address |
| l2_req_cat_o | output | 1 | L2 request category |
| l2_rsp_valid_i | input | 1 | L2 reply valid |
| l2_rsp_data_i | input | LINE_W | L2 reply line |
| fill_valid_o | output | 1 | Fetch complete pulse |
| fill_addr_o | output | ADDR_W | Filled line address |
| fill_cat_o | output | 1 | Filled line category |
| fill_data_o | output | LINE_W | Filled line |

## Verification
The assertions assume that core_id_i is constant after reset and that the local data array returns the line in the same cycle rd_en_o is high. They also assume that a requester holds each bus message steady until its handshake completes. The stimulus drives every input on the falling edge and keeps core_id_i fixed. It models the data array as a pure function of rd_addr_o. It holds sb_rx_valid_i until sb_rx_ready_o has been seen high, and it sends a response to this core only after the matching request has left.

// File: rtl/p2p_fetch_pkg.sv
package p2p_fetch_pkg;
  localparam logic STG_REQ = 1'b0;
  localparam logic STG_RSP = 1'b1;
  localparam logic ACK_HIT = 1'b0;

  typedef enum logic [2:0] {
    F_IDLE, F_WAIT_DIR, F_SEND_SB, F_WAIT_RSP, F_SEND_L2, F_WAIT_L2
  } fetch_st_e;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_SEND} serve_st_e;
endpackage

// File: rtl/p2p_msg_filter.sv
module p2p_msg_filter #(
  parameter int ID_W = 2
) (
  input  logic [ID_W-1:0] core_id_i,
  input  logic            cc_valid_i,
  input  logic            cc_stage_i,
  input  logic [ID_W-1:0] cc_src_i,
  input  logic            rx_valid_i,
  input  logic            rx_stage_i,
  input  logic [ID_W-1:0] rx_src_i,
  input  logic [ID_W-1:0] rx_dst_i,
  output logic            conf_mine_o,
  output logic            req_mine_o,
  output logic            rsp_mine_o
);
  import p2p_fetch_pkg::*;

  assign conf_mine_o = cc_valid_i && (cc_stage_i == STG_RSP) && (cc_src_i == core_id_i);
  assign req_mine_o  = rx_valid_i && (rx_stage_i == STG_REQ) && (rx_dst_i == core_id_i);
  assign rsp_mine_o  = rx_valid_i && (rx_stage_i == STG_RSP) && (rx_src_i == core_id_i);
endmodule

// File: rtl/p2p_fetch_ctrl.sv
module p2p_fetch_ctrl #(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 16,
  parameter int LINE_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  output logic              miss_ready_o,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              miss_cat_i,
  input  logic              conf_i,
  input  logic              ack_i,
  input  logic [ID_W-1:0]   owner_i,
  input  logic              rsp_take_i,
  input  logic [LINE_W-1:0] rsp_data_i,
  output logic              req_valid_o,
  input  logic              req_done_i,
  output logic [ID_W-1:0]   req_dst_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              req_cat_o,
  output logic              l2_req_valid_o,
  input  logic              l2_req_ready_i,
  input  logic              l2_rsp_valid_i,
  input  logic [LINE_W-1:0] l2_rsp_data_i,
  output logic              fill_valid_o,
  output logic [LINE_W-1:0] fill_data_o
);
  import p2p_fetch_pkg::*;

  fetch_st_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cat_q;
  logic [ID_W-1:0]   owner_q;
  logic              fill_q;
  logic [LINE_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= F_IDLE;
      addr_q  <= '0;
      cat_q   <= 1'b0;
      owner_q <= '0;
      fill_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      fill_q <= 1'b0;
      unique case (st_q)
        F_IDLE: if (miss_valid_i) begin
          addr_q <= miss_addr_i;
          cat_q  <= miss_cat_i;
          st_q   <= F_WAIT_DIR;
        end
        F_WAIT_DIR: if (conf_i) begin
          if (ack_i == ACK_HIT) begin
            owner_q <= owner_i;
            st_q    <= F_SEND_SB;
          end else begin
            st_q <= F_SEND_L2;
          end
        end
        F_SEND_SB: if (req_done_i) st_q <= F_WAIT_RSP;
        F_WAIT_RSP: if (rsp_take_i) begin
          data_q <= rsp_data_i;
          fill_q <= 1'b1;
          st_q   <= F_IDLE;
        end
        F_SEND_L2: if (l2_req_ready_i) st_q <= F_WAIT_L2;
        F_WAIT_L2: if (l2_rsp_valid_i) begin
          data_q <= l2_rsp_data_i;
          fill_q <= 1'b1;
          st_q   <= F_IDLE;
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign miss_ready_o   = (st_q == F_IDLE);
  assign req_valid_o    = (st_q == F_SEND_SB);
  assign l2_req_valid_o = (st_q == F_SEND_L2);
  assign req_dst_o      = owner_q;
  assign req_addr_o     = addr_q;
  assign req_cat_o      = cat_q;
  assign fill_valid_o   = fill_q;
  assign fill_data_o    = data_q;
endmodule

// File: rtl/p2p_serve_unit.sv
module p2p_serve_unit #(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 16,
  parameter int LINE_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              cat_i,
  input  logic [ID_W-1:0]   src_i,
  input  logic [ID_W-1:0]   dst_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [LINE_W-1:0] rd_data_i,
  output logic              rsp_valid_o,
  input  logic              rsp_done_i,
  output logic              rsp_cat_o,
  output logic [ID_W-1:0]   rsp_src_o,
  output logic [ID_W-1:0]   rsp_dst_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [LINE_W-1:0] rsp_data_o
);
  import p2p_fetch_pkg::*;

  serve_st_e         st_q;
  logic              cat_q;
  logic [ID_W-1:0]   src_q, dst_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cat_q  <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (take_i) begin
          cat_q  <= cat_i;
          src_q  <= src_i;
          dst_q  <= dst_i;
          addr_q <= addr_i;
          st_q   <= S_READ;
        end
        S_READ: begin
          data_q <= rd_data_i;
          st_q   <= S_SEND;
        end
        S_SEND: if (rsp_done_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign rd_en_o     = (st_q == S_READ);
  assign rd_addr_o   = addr_q;
  assign rsp_valid_o = (st_q == S_SEND);
  assign rsp_cat_o   = cat_q;
  assign rsp_src_o   = src_q;
  assign rsp_dst_o   = dst_q;
  assign rsp_addr_o  = addr_q;
  assign rsp_data_o  = data_q;
endmodule

// File: rtl/p2p_tx_arb.sv
module p2p_tx_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srv_valid_i,
  input  logic req_valid_i,
  input  logic tx_ready_i,
  output logic tx_valid_o,
  output logic sel_srv_o,
  output logic srv_done_o,
  output logic req_done_o
);
  logic lock_q, lock_sel_q;

  // served responses win a fresh choice; an offered message is held
  assign sel_srv_o  = lock_q ? lock_sel_q : srv_valid_i;
  assign tx_valid_o = srv_valid_i || req_valid_i;
  assign srv_done_o = tx_valid_o && tx_ready_i && sel_srv_o;
  assign req_done_o = tx_valid_o && tx_ready_i && !sel_srv_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q     <= 1'b0;
      lock_sel_q <= 1'b0;
    end else begin
      lock_q     <= tx_valid_o && !tx_ready_i;
      lock_sel_q <= sel_srv_o;
    end
  end
endmodule

// File: rtl/p2p_fetch_top.sv
module p2p_fetch_top #(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 16,
  parameter int LINE_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   core_id_i,
  input  logic              miss_valid_i,
  output logic              miss_ready_o,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              miss_cat_i,
  input  logic              cc_valid_i,
  output logic              cc_ready_o,
  input  logic              cc_stage_i,
  input  logic [ID_W-1:0]   cc_src_i,
  input  logic              cc_ack_i,
  input  logic [ID_W-1:0]   cc_owner_i,
  output logic              sb_tx_valid_o,
  input  logic              sb_tx_ready_i,
  output logic              sb_tx_stage_o,
  output logic              sb_tx_cat_o,
  output logic [ID_W-1:0]   sb_tx_src_o,
  output logic [ID_W-1:0]   sb_tx_dst_o,
  output logic [ADDR_W-1:0] sb_tx_addr_o,
  output logic [LINE_W-1:0] sb_tx_data_o,
  input  logic              sb_rx_valid_i,
  output logic              sb_rx_ready_o,
  input  logic              sb_rx_stage_i,
  input  logic              sb_rx_cat_i,
  input  logic [ID_W-1:0]   sb_rx_src_i,
  input  logic [ID_W-1:0]   sb_rx_dst_i,
  input  logic [ADDR_W-1:0] sb_rx_addr_i,
  input  logic [LINE_W-1:0] sb_rx_data_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [LINE_W-1:0] rd_data_i,
  output logic              l2_req_valid_o,
  input  logic              l2_req_ready_i,
  output logic [ADDR_W-1:0] l2_req_addr_o,
  output logic              l2_req_cat_o,
  input  logic              l2_rsp_valid_i,
  input  logic [LINE_W-1:0] l2_rsp_data_i,
  output logic              fill_valid_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  output logic              fill_cat_o,
  output logic [LINE_W-1:0] fill_data_o
);
  import p2p_fetch_pkg::*;

  logic conf_mine, req_mine, rsp_mine;
  logic srv_busy, srv_valid, srv_done, req_valid, req_done, sel_srv;
  logic srv_cat, req_cat;
  logic [ID_W-1:0]   srv_src, srv_dst, req_dst;
  logic [ADDR_W-1:0] srv_addr, req_addr;
  logic [LINE_W-1:0] srv_data;

  assign cc_ready_o    = 1'b1;
  assign sb_rx_ready_o = !srv_busy;

  p2p_msg_filter #(.ID_W(ID_W)) u_filt (
    .core_id_i  (core_id_i),
    .cc_valid_i (cc_valid_i),
    .cc_stage_i (cc_stage_i),
    .cc_src_i   (cc_src_i),
    .rx_valid_i (sb_rx_valid_i),
    .rx_stage_i (sb_rx_stage_i),
    .rx_src_i   (sb_rx_src_i),
    .rx_dst_i   (sb_rx_dst_i),
    .conf_mine_o(conf_mine),
    .req_mine_o (req_mine),
    .rsp_mine_o (rsp_mine)
  );

  p2p_fetch_ctrl #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_fetch (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .miss_valid_i  (miss_valid_i),
    .miss_ready_o  (miss_ready_o),
    .miss_addr_i   (miss_addr_i),
    .miss_cat_i    (miss_cat_i),
    .conf_i        (conf_mine),
    .ack_i         (cc_ack_i),
    .owner_i       (cc_owner_i),
    .rsp_take_i    (rsp_mine && !srv_busy),
    .rsp_data_i    (sb_rx_data_i),
    .req_valid_o   (req_valid),
    .req_done_i    (req_done),
    .req_dst_o     (req_dst),
    .req_addr_o    (req_addr),
    .req_cat_o     (req_cat),
    .l2_req_valid_o(l2_req_valid_o),
    .l2_req_ready_i(l2_req_ready_i),
    .l2_rsp_valid_i(l2_rsp_valid_i),
    .l2_rsp_data_i (l2_rsp_data_i),
    .fill_valid_o  (fill_valid_o),
    .fill_data_o   (fill_data_o)
  );

  assign l2_req_addr_o = req_addr;
  assign l2_req_cat_o  = req_cat;
  assign fill_addr_o   = req_addr;
  assign fill_cat_o    = req_cat;

  p2p_serve_unit #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_serve (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (req_mine && !srv_busy),
    .cat_i      (sb_rx_cat_i),
    .src_i      (sb_rx_src_i),
    .dst_i      (sb_rx_dst_i),
    .addr_i     (sb_rx_addr_i),
    .busy_o     (srv_busy),
    .rd_en_o    (rd_en_o),
    .rd_addr_o  (rd_addr_o),
    .rd_data_i  (rd_data_i),
    .rsp_valid_o(srv_valid),
    .rsp_done_i (srv_done),
    .rsp_cat_o  (srv_cat),
    .rsp_src_o  (srv_src),
    .rsp_dst_o  (srv_dst),
    .rsp_addr_o (srv_addr),
    .rsp_data_o (srv_data)
  );

  p2p_tx_arb u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .srv_valid_i(srv_valid),
    .req_valid_i(req_valid),
    .tx_ready_i (sb_tx_ready_i),
    .tx_valid_o (sb_tx_valid_o),
    .sel_srv_o  (sel_srv),
    .srv_done_o (srv_done),
    .req_done_o (req_done)
  );

  assign sb_tx_stage_o = sel_srv ? STG_RSP : STG_REQ;
  assign sb_tx_cat_o   = sel_srv ? srv_cat  : req_cat;
  assign sb_tx_src_o   = sel_srv ? srv_src  : core_id_i;
  assign sb_tx_dst_o   = sel_srv ? srv_dst  : req_dst;
  assign sb_tx_addr_o  = sel_srv ? srv_addr : req_addr;
  assign sb_tx_data_o  = sel_srv ? srv_data : '0;
endmodule

// File: rtl/p2p_fetch_chk.sv
module p2p_fetch_chk #(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 16,
  parameter int LINE_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ID_W-1:0]   core_id_i,
  input logic              miss_valid_i,
  input logic              miss_ready_o,
  input logic              sb_tx_valid_o,
  input logic              sb_tx_ready_i,
  input logic              sb_tx_stage_o,
  input logic [ID_W-1:0]   sb_tx_src_o,
  input logic [ID_W-1:0]   sb_tx_dst_o,
  input logic [ADDR_W-1:0] sb_tx_addr_o,
  input logic [LINE_W-1:0] sb_tx_data_o,
  input logic              sb_rx_valid_i,
  input logic              sb_rx_ready_o,
  input logic              sb_rx_stage_i,
  input logic [ID_W-1:0]   sb_rx_dst_i,
  input logic              rd_en_o,
  input logic              l2_req_valid_o,
  input logic              fill_valid_o
);
  AST_ONE_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i && miss_ready_o |=> !miss_ready_o); // R2
  AST_FILL_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |-> miss_ready_o); // R10
  AST_REQ_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_tx_valid_o && !sb_tx_stage_o |-> sb_tx_src_o == core_id_i && sb_tx_data_o == '0); // R4
  AST_ROUTE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l2_req_valid_o && sb_tx_valid_o && !sb_tx_stage_o)); // R5
  AST_RSP_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_tx_valid_o && sb_tx_stage_o |-> sb_tx_dst_o == core_id_i); // R6
  AST_READ_AFTER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_rx_valid_i && sb_rx_ready_o && !sb_rx_stage_i && sb_rx_dst_i == core_id_i |=> rd_en_o); // R6
  AST_FOREIGN_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_rx_valid_i && sb_rx_ready_o && !sb_rx_stage_i && sb_rx_dst_i != core_id_i |=> !rd_en_o); // R7
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_tx_valid_o && !sb_tx_ready_i |=> sb_tx_valid_o && $stable(sb_tx_stage_o) &&
      $stable(sb_tx_dst_o) && $stable(sb_tx_addr_o) && $stable(sb_tx_data_o)); // R9
  AST_FILL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |=> !fill_valid_o); // R10
endmodule

bind p2p_fetch_top p2p_fetch_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (.*);

// File: tb/sim_p2p_fetch_top.sv
`timescale 1ns/1ps
module sim_p2p_fetch_top;
  localparam int ID_W = 2, ADDR_W = 16, LINE_W = 64;
  localparam logic [ID_W-1:0] ME = 2'd1;

  typedef struct packed {
    logic cat; logic [ID_W-1:0] src; logic [ID_W-1:0] dst;
    logic [ADDR_W-1:0] addr; logic [LINE_W-1:0] data;
  } bmsg_t;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic miss_valid = 0, miss_cat = 0; logic [ADDR_W-1:0] miss_addr = 0;
  logic cc_valid = 0, cc_stage = 0, cc_ack = 0; logic [ID_W-1:0] cc_src = 0, cc_owner = 0;
  logic tx_ready = 1;
  logic rx_valid = 0, rx_stage = 0, rx_cat = 0; logic [ID_W-1:0] rx_src = 0, rx_dst = 0;
  logic [ADDR_W-1:0] rx_addr = 0; logic [LINE_W-1:0] rx_data = 0;
  logic l2_ready = 1, l2_rsp_valid = 0; logic [LINE_W-1:0] l2_rsp_data = 0;

  logic miss_ready, cc_ready, tx_valid, tx_stage, tx_cat, rx_ready, rd_en, l2_valid, l2_cat;
  logic fill_valid, fill_cat;
  logic [ID_W-1:0] tx_src, tx_dst;
  logic [ADDR_W-1:0] tx_addr, rd_addr, l2_addr, fill_addr;
  logic [LINE_W-1:0] tx_data, rd_data, fill_data;

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return {a ^ 16'hA5C3, ~a, a, a + 16'h0101};
  endfunction
  assign rd_data = line_of(rd_addr);

  p2p_fetch_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .core_id_i(ME),
    .miss_valid_i(miss_valid), .miss_ready_o(miss_ready), .miss_addr_i(miss_addr), .miss_cat_i(miss_cat),
    .cc_valid_i(cc_valid), .cc_ready_o(cc_ready), .cc_stage_i(cc_stage), .cc_src_i(cc_src),
    .cc_ack_i(cc_ack), .cc_owner_i(cc_owner),
    .sb_tx_valid_o(tx_valid), .sb_tx_ready_i(tx_ready), .sb_tx_stage_o(tx_stage), .sb_tx_cat_o(tx_cat),
    .sb_tx_src_o(tx_src), .sb_tx_dst_o(tx_dst), .sb_tx_addr_o(tx_addr), .sb_tx_data_o(tx_data),
    .sb_rx_valid_i(rx_valid), .sb_rx_ready_o(rx_ready), .sb_rx_stage_i(rx_stage), .sb_rx_cat_i(rx_cat),
    .sb_rx_src_i(rx_src), .sb_rx_dst_i(rx_dst), .sb_rx_addr_i(rx_addr), .sb_rx_data_i(rx_data),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .l2_req_valid_o(l2_valid), .l2_req_ready_i(l2_ready), .l2_req_addr_o(l2_addr), .l2_req_cat_o(l2_cat),
    .l2_rsp_valid_i(l2_rsp_valid), .l2_rsp_data_i(l2_rsp_data),
    .fill_valid_o(fill_valid), .fill_addr_o(fill_addr), .fill_cat_o(fill_cat), .fill_data_o(fill_data)
  );

  int n_run = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 wait directory, 2 wait remote, 3 wait L2
  int mst = 0;
  logic [ADDR_W-1:0] m_addr = 0; logic m_cat = 0;
  bmsg_t q_req[$], q_rsp[$], q_l2[$];
  int fire_log[$];
  bit fill_due = 0, rd_due = 0, hold_chk = 0;
  logic [LINE_W-1:0] fill_exp = 0; logic [ADDR_W-1:0] rd_exp = 0;
  bmsg_t held, s_tx; logic s_tx_valid = 0, s_tx_stage = 0, s_rx_ready = 0, s_l2_valid = 0;
  logic [ADDR_W-1:0] s_l2_addr = 0; logic s_l2_cat = 0;
  int tx_fired = 0, l2_fired = 0;

  always @(negedge clk) if (rst_n) begin
    chk(miss_ready == (mst == 0), "R2", "miss_ready", miss_ready, mst == 0);
    chk(fill_valid == fill_due, "R10", "fill_valid", fill_valid, fill_due);
    if (fill_due) begin
      chk(fill_data == fill_exp, "R8", "fill_data", fill_data, fill_exp);
      chk(fill_addr == m_addr && fill_cat == m_cat, "R10", "fill_addr", fill_addr, m_addr);
    end
    chk(rd_en == rd_due, "R7", "rd_en", rd_en, rd_due);
    if (rd_due) chk(rd_addr == rd_exp, "R6", "rd_addr", rd_addr, rd_exp);
    if (hold_chk)
      chk(tx_valid && {tx_cat, tx_src, tx_dst, tx_addr, tx_data} == held && tx_stage == s_tx_stage,
          "R9", "held payload", tx_addr, held.addr);
    if (tx_valid && tx_stage == 1'b0 && q_req.size() == 0)
      chk(0, "R3", "unexpected request", tx_addr, 0);
    if (tx_valid && tx_stage == 1'b1 && q_rsp.size() == 0)
      chk(0, "R7", "unexpected response", tx_addr, 0);
    if (l2_valid && q_l2.size() == 0) chk(0, "R5", "unexpected l2 request", l2_addr, 0);
    s_tx_valid = tx_valid; s_tx_stage = tx_stage;
    s_tx = '{cat: tx_cat, src: tx_src, dst: tx_dst, addr: tx_addr, data: tx_data};
    s_rx_ready = rx_ready; s_l2_valid = l2_valid; s_l2_addr = l2_addr; s_l2_cat = l2_cat;
  end

  always @(posedge clk) if (rst_n) begin
    bmsg_t e;
    fill_due = 0; rd_due = 0; hold_chk = 0;
    if (s_tx_valid && tx_ready) begin
      tx_fired++; fire_log.push_back(int'(s_tx_stage));
      if (!s_tx_stage && q_req.size() > 0) begin
        e = q_req.pop_front(); chk(s_tx == e, "R4", "request", s_tx, e);
      end else if (s_tx_stage && q_rsp.size() > 0) begin
        e = q_rsp.pop_front(); chk(s_tx == e, "R6", "response", s_tx, e);
      end
    end else if (s_tx_valid) begin
      hold_chk = 1; held = s_tx;
    end
    if (s_l2_valid && l2_ready && q_l2.size() > 0) begin
      l2_fired++; e = q_l2.pop_front();
      chk(s_l2_addr == e.addr && s_l2_cat == e.cat, "R5", "l2 request", s_l2_addr, e.addr);
    end
    if (rx_valid && s_rx_ready) begin
      if (!rx_stage && rx_dst == ME) begin
        q_rsp.push_back('{cat: rx_cat, src: rx_src, dst: rx_dst, addr: rx_addr, data: line_of(rx_addr)});
        rd_due = 1; rd_exp = rx_addr;
      end
      if (rx_stage && rx_src == ME && mst == 2) begin
        fill_due = 1; fill_exp = rx_data; mst = 0;
      end
    end
    if (l2_rsp_valid && mst == 3) begin fill_due = 1; fill_exp = l2_rsp_data; mst = 0; end
    if (cc_valid && cc_stage && cc_src == ME && mst == 1) begin
      if (!cc_ack) begin
        q_req.push_back('{cat: m_cat, src: ME, dst: cc_owner, addr: m_addr, data: '0}); mst = 2;
      end else begin
        q_l2.push_back('{cat: m_cat, src: ME, dst: '0, addr: m_addr, data: '0}); mst = 3;
      end
    end
    if (miss_valid && mst == 0) begin mst = 1; m_addr = miss_addr; m_cat = miss_cat; end
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic do_miss(input logic [ADDR_W-1:0] a, input logic c);
    @(negedge clk); miss_valid = 1; miss_addr = a; miss_cat = c;
    while (!miss_ready) @(negedge clk);
    @(negedge clk); miss_valid = 0;
  endtask
  task automatic send_cc(input logic st, input logic [ID_W-1:0] src, input logic ack, input logic [ID_W-1:0] own);
    @(negedge clk); cc_valid = 1; cc_stage = st; cc_src = src; cc_ack = ack; cc_owner = own;
    @(negedge clk); cc_valid = 0;
  endtask
  task automatic send_rx(input logic st, input logic c, input logic [ID_W-1:0] src, input logic [ID_W-1:0] dst,
                         input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] d);
    @(negedge clk); rx_valid = 1; rx_stage = st; rx_cat = c; rx_src = src; rx_dst = dst; rx_addr = a; rx_data = d;
    while (!rx_ready) @(negedge clk);
    @(negedge clk); rx_valid = 0;
  endtask
  task automatic wait_tx(input int n); while (tx_fired < n) @(negedge clk); endtask

  task automatic run_all();
    cyc(3); rst_n = 1;
    @(negedge clk);
    chk(miss_ready && !tx_valid && !l2_valid && !rd_en && !fill_valid, "R1", "reset outputs",
        {miss_ready, tx_valid, l2_valid, rd_en, fill_valid}, 5'b10000);
    // remote fetch, with filtered noise
    do_miss(16'h1234, 1'b0);
    @(negedge clk); miss_valid = 1; miss_addr = 16'h7777; miss_cat = 1; cyc(3); miss_valid = 0; // R2 ignored
    send_cc(1'b0, ME, 1'b0, 2'd3);   // R3 stage 0
    send_cc(1'b1, 2'd2, 1'b0, 2'd3); // R3 foreign source
    cyc(3);
    send_cc(1'b1, ME, 1'b0, 2'd3);   // R4 hit
    wait_tx(1);
    send_rx(1'b1, 1'b0, 2'd2, 2'd3, 16'h1234, 64'hBAD0); // R8 foreign response
    cyc(2);
    send_rx(1'b1, 1'b0, ME, 2'd3, 16'h1234, 64'hCAFE_F00D_1234_5678); // R8
    cyc(3);
    send_rx(1'b1, 1'b0, ME, 2'd3, 16'h1234, 64'h1); // R8 nothing waiting
    send_cc(1'b1, ME, 1'b0, 2'd2); // R3 nothing waiting
    cyc(3);
    // L2 path with stalled ready
    do_miss(16'h0040, 1'b1);
    @(negedge clk); l2_ready = 0;
    send_cc(1'b1, ME, 1'b1, 2'd0); // R5
    cyc(4); l2_ready = 1;
    while (l2_fired < 1) @(negedge clk);
    cyc(2); l2_rsp_valid = 1; l2_rsp_data = 64'h0123_4567_89AB_CDEF;
    @(negedge clk); l2_rsp_valid = 0;
    cyc(3);
    // serving requests
    send_rx(1'b0, 1'b0, 2'd2, ME, 16'h0BEE, 64'h0);  // R6
    wait_tx(2);
    send_rx(1'b0, 1'b1, 2'd0, 2'd3, 16'h0DAD, 64'h0); // R7 foreign destination
    cyc(4);
    send_rx(1'b0, 1'b1, 2'd3, ME, 16'hF00F, 64'h0);  // R6 write category
    wait_tx(3);
    // contention under back-pressure
    @(negedge clk); tx_ready = 0;
    do_miss(16'h2222, 1'b0);
    send_cc(1'b1, ME, 1'b0, 2'd2);
    cyc(3);
    send_rx(1'b0, 1'b0, 2'd3, ME, 16'h3333, 64'h0);
    cyc(4); tx_ready = 1;
    wait_tx(5);
    chk(fire_log.size() >= 5 && fire_log[3] == 0 && fire_log[4] == 1, "R9", "order after stall",
        fire_log.size(), 5);
    send_rx(1'b1, 1'b0, ME, 2'd2, 16'h2222, 64'hDEAD_BEEF_0000_0001); // R8
    cyc(5);
    chk(q_req.size() == 0 && q_rsp.size() == 0 && q_l2.size() == 0 && mst == 0, "R4", "drained",
        q_req.size() + q_rsp.size() + q_l2.size(), 0);
  endtask

  initial begin
    bit timeout = 0;
    fork
      run_all();
      begin repeat (20000) @(posedge clk); timeout = 1; end
    join_any
    if (timeout) chk(0, "R1", "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule